// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block is the software-facing bookkeeping for the transmit buffers of a CAN controller. Each buffer has an empty flag, an abort request bit, an abort acknowledge flag and an interrupt enable. Software schedules a buffer by clearing its empty flag. It may then ask for that buffer to be withdrawn. The transmit engine reports, one pulse per event and per buffer, when a buffer starts going out on the bus and how the attempt ended: success, lost arbitration or a bus error.

The controller decides whether each abort request can be honoured. An abort is granted while the buffer is still waiting, or at the end of an attempt that failed. It is never granted in the middle of an attempt that goes on to succeed. When it grants an abort, the buffer becomes empty again and the acknowledge flag records that the message was withdrawn. The transmit interrupt request is raised from the empty flags of the buffers whose interrupts are enabled.

A soft-reset input keeps the control register at its reset value. The register port is a plain single-cycle write strobe with a combinational read. Only one register is written per cycle.

Top module: `can_txab_ctrl`

## Requirements
- R1: After hardware reset, every empty flag reads 1, every acknowledge flag reads 0, the control register reads 0 and `irq` is 0.
- R2: In the control register (address 1), buffer i has its abort request at bit 4+i and its interrupt enable at bit i. Bits 3 and 7 always read 0. The enables are written directly.
- R3: In the flag register (address 0), buffer i has its empty flag at bit i and its acknowledge flag at bit 4+i. Writing 1 to an empty-flag bit clears that flag and so schedules the buffer. Writing 0 has no effect. The acknowledge bits ignore writes.
- R4: An abort request bit can only be set to 1, and only while the buffer's empty flag is 0. Writing 0 leaves it unchanged. A set aimed at an empty buffer is ignored.
- R5: A pending abort on a buffer that is not being transmitted is granted at the next clock edge: the empty flag and the acknowledge flag both become 1.
- R6: When an attempt ends with lost arbitration or an error while an abort is pending, the abort is granted at that edge. If no abort is pending, the buffer stays scheduled.
- R7: While an attempt is in progress, a pending abort is held and not granted. A successful completion sets the empty flag and leaves the acknowledge flag at 0.
- R8: An abort request bit clears at the edge at which the empty flag of the same buffer becomes 1, whatever the reason.
- R9: Scheduling a buffer clears its acknowledge flag.
- R10: `irq` is 1 exactly when some buffer has both its empty flag and its interrupt enable at 1.
- R11: While `soft_rst` is 1, the control register is held at 0 and writes to it are ignored. A held abort request is therefore never granted.
- R12: If an attempt starts in the same cycle that an abort request is written, the attempt wins. The request stays pending and is decided by how the attempt ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Holds the control register at its reset value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| tx_start | input | 3 | Per-buffer pulse: transmission of the buffer begins |
| tx_ok | input | 3 | Per-buffer pulse: attempt completed successfully |
| tx_arb_lost | input | 3 | Per-buffer pulse: attempt lost arbitration |
| tx_err | input | 3 | Per-buffer pulse: attempt ended in a bus error |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The case that is hardest to reach from the ports is the race between the transmit engine and software. An abort written in the very cycle an attempt starts must stay pending until the attempt ends, and only then be granted, or dropped if the attempt succeeds. The bench drives the start pulse and the control write in the same cycle. It confirms over several idle cycles that the buffer stays scheduled, then closes the attempt with an error pulse and checks the grant. The other completions are handled in the same way, with an abort pending and without one. All 256 control-register write values are swept while every buffer is empty, which covers the rule that a set on an empty buffer is ignored and the interrupt function.

// File: rtl/can_txab_pkg.sv
package can_txab_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned HALF_W    = REG_W / 2;
   localparam logic        ADDR_FLAG = 1'b0;
   localparam logic        ADDR_CTRL = 1'b1;
endpackage

// File: rtl/can_txab_slot.sv
module can_txab_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic sched_wr,
   input  logic areq_wr,
   input  logic ie_wr_en,
   input  logic ie_wdata,
   input  logic tx_start,
   input  logic tx_ok,
   input  logic tx_fail,
   output logic txe,
   output logic ack,
   output logic areq,
   output logic ie,
   output logic busy
);
   logic txe_q, ack_q, areq_q, ie_q, busy_q;
   logic start_go, fin_ok, fin_fail, grant, set_txe, sched, areq_set;

   always_comb begin
      start_go = tx_start & ~txe_q & ~busy_q;
      fin_ok   = busy_q & tx_ok;
      fin_fail = busy_q & tx_fail;
      // transmission that starts this cycle takes precedence over a waiting abort
      grant    = areq_q & ((~busy_q & ~start_go) | fin_fail);
      set_txe  = grant | fin_ok;
      sched    = sched_wr & txe_q;
      areq_set = areq_wr & ~txe_q & ~soft_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe_q  <= 1'b1;
         ack_q  <= 1'b0;
         areq_q <= 1'b0;
         ie_q   <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (start_go)
            busy_q <= 1'b1;
         else if (fin_ok | fin_fail)
            busy_q <= 1'b0;

         if (set_txe)
            txe_q <= 1'b1;
         else if (sched)
            txe_q <= 1'b0;

         if (set_txe)
            ack_q <= grant;
         else if (sched)
            ack_q <= 1'b0;

         if (soft_rst | set_txe)
            areq_q <= 1'b0;
         else if (areq_set)
            areq_q <= 1'b1;

         if (soft_rst)
            ie_q <= 1'b0;
         else if (ie_wr_en)
            ie_q <= ie_wdata;
      end
   end

   assign txe  = txe_q;
   assign ack  = ack_q;
   assign areq = areq_q;
   assign ie   = ie_q;
   assign busy = busy_q;
endmodule

// File: rtl/can_txab_bus.sv
module can_txab_bus
   import can_txab_pkg::*;
#(
   parameter int unsigned NUM_BUF = 3
) (
   input  logic               bus_wr,
   input  logic               bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   input  logic [NUM_BUF-1:0] txe,
   input  logic [NUM_BUF-1:0] ack,
   input  logic [NUM_BUF-1:0] areq,
   input  logic [NUM_BUF-1:0] ie,
   output logic [NUM_BUF-1:0] sched_wr,
   output logic [NUM_BUF-1:0] areq_wr,
   output logic               ie_wr_en,
   output logic [NUM_BUF-1:0] ie_wdata,
   output logic [REG_W-1:0]   bus_rdata
);
   logic wr_flag, wr_ctrl;
   logic wdata_unused;

   assign wr_flag      = bus_wr & (bus_addr == ADDR_FLAG);
   assign wr_ctrl      = bus_wr & (bus_addr == ADDR_CTRL);
   assign wdata_unused = ^bus_wdata;

   assign sched_wr = {NUM_BUF{wr_flag}} & bus_wdata[0 +: NUM_BUF];
   assign areq_wr  = {NUM_BUF{wr_ctrl}} & bus_wdata[HALF_W +: NUM_BUF];
   assign ie_wr_en = wr_ctrl;
   assign ie_wdata = bus_wdata[0 +: NUM_BUF];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_FLAG) begin
         bus_rdata[0 +: NUM_BUF]      = txe;
         bus_rdata[HALF_W +: NUM_BUF] = ack;
      end else begin
         bus_rdata[0 +: NUM_BUF]      = ie;
         bus_rdata[HALF_W +: NUM_BUF] = areq;
      end
   end
endmodule

// File: rtl/can_txab_ctrl.sv
module can_txab_ctrl
   import can_txab_pkg::*;
#(
   parameter int unsigned NUM_BUF = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               bus_wr,
   input  logic               bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_BUF-1:0] tx_start,
   input  logic [NUM_BUF-1:0] tx_ok,
   input  logic [NUM_BUF-1:0] tx_arb_lost,
   input  logic [NUM_BUF-1:0] tx_err,
   output logic               irq
);
   localparam int unsigned MAX_BUF = HALF_W - 1;

   generate
      if (NUM_BUF < 1 || NUM_BUF > MAX_BUF) begin : g_bad_cfg
         $error("can_txab_ctrl: NUM_BUF must lie in 1..HALF_W-1");
      end
   endgenerate

   logic [NUM_BUF-1:0] txe_w, ack_w, areq_w, ie_w, busy_w;
   logic [NUM_BUF-1:0] sched_wr_w, areq_wr_w, ie_wdata_w;
   logic               ie_wr_en_w;
   logic               irq_c;

   can_txab_bus #(.NUM_BUF(NUM_BUF)) bus_i (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .txe       (txe_w),
      .ack       (ack_w),
      .areq      (areq_w),
      .ie        (ie_w),
      .sched_wr  (sched_wr_w),
      .areq_wr   (areq_wr_w),
      .ie_wr_en  (ie_wr_en_w),
      .ie_wdata  (ie_wdata_w),
      .bus_rdata (bus_rdata)
   );

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
      can_txab_slot slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .sched_wr (sched_wr_w[i]),
         .areq_wr  (areq_wr_w[i]),
         .ie_wr_en (ie_wr_en_w),
         .ie_wdata (ie_wdata_w[i]),
         .tx_start (tx_start[i]),
         .tx_ok    (tx_ok[i]),
         .tx_fail  (tx_arb_lost[i] | tx_err[i]),
         .txe      (txe_w[i]),
         .ack      (ack_w[i]),
         .areq     (areq_w[i]),
         .ie       (ie_w[i]),
         .busy     (busy_w[i])
      );
   end

   assign irq_c = |(txe_w & ie_w);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate
endmodule

// File: rtl/can_txab_chk.sv
module can_txab_chk #(
   parameter int unsigned NUM_BUF = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic [NUM_BUF-1:0] txe,
   input logic [NUM_BUF-1:0] ack,
   input logic [NUM_BUF-1:0] areq,
   input logic [NUM_BUF-1:0] ie,
   input logic [NUM_BUF-1:0] busy,
   input logic [NUM_BUF-1:0] tx_start,
   input logic [NUM_BUF-1:0] tx_ok,
   input logic [NUM_BUF-1:0] tx_fail
);
   assert_soft_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ie == '0) && (areq == '0));

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
      assert_areq_sched_R4: assert property (@(posedge clk) disable iff (!rst_n)
         areq[i] |-> !txe[i]);
      assert_idle_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
         areq[i] && !busy[i] && !tx_start[i] |=> txe[i] && ack[i] && !areq[i]);
      assert_fail_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
         busy[i] && tx_fail[i] && areq[i] |=> txe[i] && ack[i]);
      assert_ok_noack_R7: assert property (@(posedge clk) disable iff (!rst_n)
         busy[i] && tx_ok[i] && !tx_fail[i] |=> txe[i] && !ack[i]);
      assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
         busy[i] && !tx_ok[i] && !tx_fail[i] |=> !txe[i]);
      assert_sched_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(txe[i]) |-> !ack[i]);
   end
endmodule

bind can_txab_ctrl can_txab_chk #(.NUM_BUF(NUM_BUF)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .txe      (txe_w),
   .ack      (ack_w),
   .areq     (areq_w),
   .ie       (ie_w),
   .busy     (busy_w),
   .tx_start (tx_start),
   .tx_ok    (tx_ok),
   .tx_fail  (tx_arb_lost | tx_err)
);

// File: tb/can_txab_ctrl_tb.sv
module can_txab_ctrl_tb_top;
   localparam int CLK_P = 10;
   localparam int NB    = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [NB-1:0] tx_start = '0, tx_ok = '0, tx_arb_lost = '0, tx_err = '0;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   can_txab_ctrl #(.NUM_BUF(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .tx_start(tx_start), .tx_ok(tx_ok), .tx_arb_lost(tx_arb_lost),
      .tx_err(tx_err), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   // kind: 0 start, 1 success, 2 lost arbitration, 3 error
   task automatic pulse(input int kind, input int b);
      @(negedge clk);
      case (kind)
         0: tx_start[b] = 1'b1;
         1: tx_ok[b] = 1'b1;
         2: tx_arb_lost[b] = 1'b1;
         default: tx_err[b] = 1'b1;
      endcase
      @(negedge clk);
      tx_start = '0; tx_ok = '0; tx_arb_lost = '0; tx_err = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] exp_ack;
      exp_ack = '0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(1'b0, d); chk("R1 flags", d, 8'h07);
      rd(1'b1, d); chk("R1 ctrl", d, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);

      // R2 R4 R10 sweep all control values with every buffer empty
      for (int v = 0; v < 256; v++) begin
         wr(1'b1, 8'(v));
         rd(1'b1, d); chk("R2/R4 ctrl sweep", d, 8'(v) & 8'h07);
         chk("R10 irq sweep", {7'b0, irq}, {7'b0, ((v & 7) != 0)});
      end
      wr(1'b1, 8'h00);

      // R3 R4 R5 R8 per-buffer idle abort
      for (int b = 0; b < NB; b++) begin
         wr(1'b0, 8'(1 << b));
         rd(1'b0, d); chk("R3 schedule", d, (8'h07 & ~8'(1 << b)) | exp_ack);
         wr(1'b0, 8'h00);
         rd(1'b0, d); chk("R3 write zero", d, (8'h07 & ~8'(1 << b)) | exp_ack);
         wr(1'b1, 8'h00);
         rd(1'b1, d); chk("R4 write zero", d, 8'h00);
         wr(1'b1, 8'(1 << (4 + b)));
         rd(1'b1, d); chk("R4 set request", d, 8'(1 << (4 + b)));
         idle(1);
         exp_ack = exp_ack | 8'(1 << (4 + b));
         rd(1'b0, d); chk("R5 idle grant", d, 8'h07 | exp_ack);
         rd(1'b1, d); chk("R8 request cleared", d, 8'h00);
      end

      // R9 rescheduling clears acknowledge
      wr(1'b0, 8'h01);
      rd(1'b0, d); chk("R9 ack cleared", d & 8'h11, 8'h00);

      // R7 R6: abort held during attempt, lost arbitration grants
      pulse(0, 0);
      wr(1'b1, 8'h10);
      idle(3);
      rd(1'b0, d); chk("R7 held while busy", d & 8'h11, 8'h00);
      rd(1'b1, d); chk("R7 request pending", d, 8'h10);
      pulse(2, 0);
      rd(1'b0, d); chk("R6 arb-lost grant", d & 8'h11, 8'h11);
      rd(1'b1, d); chk("R8 cleared on grant", d, 8'h00);

      // R6 error grant on buffer 1
      wr(1'b0, 8'h02);
      pulse(0, 1);
      wr(1'b1, 8'h20);
      idle(2);
      rd(1'b0, d); chk("R7 held busy b1", d & 8'h22, 8'h00);
      pulse(3, 1);
      rd(1'b0, d); chk("R6 error grant", d & 8'h22, 8'h22);

      // R7 success with abort pending on buffer 2
      wr(1'b0, 8'h04);
      pulse(0, 2);
      wr(1'b1, 8'h40);
      pulse(1, 2);
      rd(1'b0, d); chk("R7 success no ack", d & 8'h44, 8'h04);
      rd(1'b1, d); chk("R8 cleared on success", d, 8'h00);

      // R6 failure without request keeps buffer scheduled, then R5 grant
      wr(1'b0, 8'h04);
      pulse(0, 2);
      pulse(3, 2);
      rd(1'b0, d); chk("R6 fail no request", d & 8'h44, 8'h00);
      wr(1'b1, 8'h40);
      idle(1);
      rd(1'b0, d); chk("R5 grant after failed try", d & 8'h44, 8'h44);

      // R12 start and abort in the same cycle
      wr(1'b0, 8'h02);
      @(negedge clk);
      tx_start[1] = 1'b1;
      bus_addr = 1'b1; bus_wdata = 8'h20; bus_wr = 1'b1;
      @(negedge clk);
      tx_start = '0; bus_wr = 1'b0; bus_wdata = '0;
      idle(2);
      rd(1'b0, d); chk("R12 transmission wins", d & 8'h22, 8'h00);
      rd(1'b1, d); chk("R12 request kept", d, 8'h20);
      pulse(3, 1);
      rd(1'b0, d); chk("R12 decided by outcome", d & 8'h22, 8'h22);

      // R10 interrupt follows empty flags
      wr(1'b0, 8'h07);
      wr(1'b1, 8'h07);
      chk("R10 all scheduled", {7'b0, irq}, 8'h00);
      wr(1'b1, 8'h17);
      idle(1);
      chk("R10 abort raises irq", {7'b0, irq}, 8'h01);

      // R11 soft reset holds control register
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk);
      rd(1'b1, d); chk("R11 held at zero", d, 8'h00);
      chk("R11 irq off", {7'b0, irq}, 8'h00);
      wr(1'b1, 8'h27);
      rd(1'b1, d); chk("R11 write ignored", d, 8'h00);
      idle(2);
      rd(1'b0, d); chk("R11 no grant", d & 8'h22, 8'h00);
      soft_rst = 1'b0;
      idle(1);
      rd(1'b1, d); chk("R11 after release", d, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule